// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration slave of a multi-channel converter. A host reaches it over three wires: an active-low select, a serial clock and one shared data line. Every access opens with a 16-bit instruction word that carries a direction flag, a byte count and a 13-bit register address. One or more data bytes follow. The block runs from a fast system clock and oversamples the three wires, so all of its state lives in one clock domain.

The register space has three groups. The first holds chip-level settings and fixed identity bytes. The second holds the channel-enable masks and a commit register. The third holds the per-channel function registers. A function-register write lands only in the shadow copies of the channels that are currently enabled. The active copies, which drive the converter, change all at once when the host sets the commit bit. The per-channel output-drive selection is taken from the active copies, and a lookup port lets the datapath read any active byte.

Top module: `spi3w_cfg_port`

## Requirements
- R1: The instruction word is 16 bits, sent MSB first and sampled on rising `sclk`. Bit 15 is the direction (1 = read). Bits 14:13 are the byte count. Bits 12:0 are the address, and all 13 address bits are decoded. Each data byte follows the word MSB first.
- R2: While `cs_n` is high, `sclk` and `sdio_i` have no effect. If `cs_n` rises partway through a data byte, that byte is discarded.
- R3: A byte count of 0, 1 or 2 allows 1, 2 or 3 bytes. Extra bytes are neither written nor driven. A count of 3 streams until `cs_n` rises. The address advances by one after each byte.
- R4: `sdio_oe` is high only during the data phase of a read, and only for bytes within the count. Read data changes only after a falling `sclk`.
- R5: Address 0x000 is a read/write general byte that resets to 0x00. Address 0x001 returns CHIP_ID (default 0x5A). Address 0x002 returns DEV_GRADE (default 0x03). Writes to 0x001 and 0x002 are ignored.
- R6: Address 0x004 bits 3:0 enable channels 0–3. Address 0x005 bits 3:0 enable channels 4–7. Both reset to 0xF, and their upper bits read 0.
- R7: A write to 0x008–0x022 updates the shadow copy of every enabled channel. A read of that range returns the shadow copy of the lowest-numbered enabled channel, or 0x00 when no channel is enabled.
- R8: Writing a byte with bit 0 set to address 0xFF copies every shadow copy of every channel into the active copies in one step. Address 0xFF reads 0x00. A write with bit 0 clear, or any other write, leaves the active copies unchanged.
- R9: `lowpwr_mode[c]` is bit 6 of channel c's active register 0x014 (0 = standard swing, 1 = reduced swing). It resets to 0.
- R10: Addresses 0x003, 0x006, 0x007, 0x023–0x0FE and everything above 0x0FF read 0x00, and writes to them are ignored.
- R11: One clock after `act_ch` and `act_idx` are presented, `act_data` shows the active byte of channel `act_ch` at address 0x008+`act_idx`. It shows 0x00 when `act_idx` is 27 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe | output | 1 | Output enable for the data pin |
| act_ch | input | 3 | Channel for the active-register lookup |
| act_idx | input | 5 | Function-register index for the lookup |
| act_data | output | 8 | Active byte at the looked-up location |
| lowpwr_mode | output | 8 | Per-channel reduced-swing drive select |

## Verification
The bench writes through partial channel masks and then commits. A design that ignores the mask would overwrite disabled channels, and one that commits early would move the drive-select outputs before the commit write. It sends more bytes than the count allows and checks both that the extra write was dropped and that the output enable fell. An off-by-one count check would write one byte too many or stop driving one byte too soon. It also toggles the clock with select high, aborts a transfer mid-byte, and touches unmapped and wide addresses. Each of these would corrupt the general byte, or leave a value where zero is expected, in a design that decodes them wrongly.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int ADDR_W = 13;
  localparam int HDR_W  = 16;

  localparam logic [ADDR_W-1:0] A_GENCFG  = 13'h000;
  localparam logic [ADDR_W-1:0] A_CHIPID  = 13'h001;
  localparam logic [ADDR_W-1:0] A_GRADE   = 13'h002;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 13'h004;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 13'h005;
  localparam logic [ADDR_W-1:0] A_COMMIT  = 13'h0FF;
  localparam logic [ADDR_W-1:0] A_FN_LO   = 13'h008;
  localparam logic [ADDR_W-1:0] A_FN_HI   = 13'h022;
  localparam logic [ADDR_W-1:0] A_DRIVE   = 13'h014;

  localparam int FN_N      = int'(A_FN_HI - A_FN_LO) + 1;
  localparam int DRIVE_IDX = int'(A_DRIVE - A_FN_LO);
  localparam int DRIVE_BIT = 6;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES*W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[(STAGES-1)*W-1:0], d};
  end

  assign q = chain[STAGES*W-1 -: W];
endmodule

// File: rtl/spi3w_serial.sv
module spi3w_serial
  import spi3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdio_o,
  output logic              sdio_oe
);
  localparam int HCNT_W = $clog2(HDR_W);

  logic              sclk_q;
  logic [HCNT_W-1:0] hcnt;
  logic [HDR_W-2:0]  hsr;
  logic              in_data, rw;
  logic [1:0]        wcnt, bdone;
  logic [2:0]        bidx;
  logic [6:0]        dsr, rbyte;

  wire rise     = sclk_s & ~sclk_q & ~cs_n_s;
  wire fall     = ~sclk_s & sclk_q & ~cs_n_s;
  wire in_limit = (wcnt == 2'b11) || (bdone <= wcnt);

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0; hsr <= '0; in_data <= 1'b0; rw <= 1'b0; wcnt <= '0;
      acc_addr <= '0; bidx <= '0; bdone <= '0; dsr <= '0; rbyte <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; sdio_o <= 1'b0; sdio_oe <= 1'b0;
    end else if (cs_n_s) begin
      hcnt <= '0; in_data <= 1'b0; bidx <= '0; bdone <= '0;
      wr_stb <= 1'b0; sdio_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (rise) begin
        if (!in_data) begin
          hsr  <= {hsr[HDR_W-3:0], sdi_s};
          hcnt <= hcnt + 1'b1;
          if (hcnt == HCNT_W'(HDR_W - 1)) begin
            rw       <= hsr[HDR_W-2];
            wcnt     <= hsr[HDR_W-3:HDR_W-4];
            acc_addr <= {hsr[ADDR_W-2:0], sdi_s};
            in_data  <= 1'b1;
            bidx     <= '0;
            bdone    <= '0;
          end
        end else begin
          dsr  <= {dsr[5:0], sdi_s};
          bidx <= bidx + 1'b1;
          if (bidx == 3'd7) begin
            if (!rw && in_limit) begin
              wr_stb  <= 1'b1;
              wr_addr <= acc_addr;
              wr_data <= {dsr, sdi_s};
            end
            acc_addr <= acc_addr + 1'b1;
            if (bdone != 2'b11) bdone <= bdone + 1'b1;
          end
        end
      end
      if (fall && in_data && rw) begin
        if (bidx == 3'd0) begin
          rbyte  <= rd_data[6:0];
          sdio_o <= rd_data[7];
        end else begin
          sdio_o <= rbyte[3'd7 - bidx];
        end
        sdio_oe <= in_limit;
      end
    end
  end

  // R4
  oe_cs_chk: assert property (@(posedge clk) disable iff (rst) cs_n_s |=> !sdio_oe);
  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst) sdio_oe |-> rw);
  // R4
  dout_fall_chk: assert property (@(posedge clk) disable iff (rst) !fall |=> $stable(sdio_o));
  // R4
  wr_dir_chk: assert property (@(posedge clk) disable iff (rst) wr_stb |-> !sdio_oe);
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter int         NUM_CH    = 8,
  parameter logic [7:0] CHIP_ID   = 8'h5A,
  parameter logic [7:0] DEV_GRADE = 8'h03,
  localparam int        CH_W      = $clog2(NUM_CH),
  localparam int        IDX_W     = $clog2(FN_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [CH_W-1:0]   act_ch,
  input  logic [IDX_W-1:0]  act_idx,
  output logic [7:0]        act_data,
  output logic [NUM_CH-1:0] lowpwr_mode
);
  localparam int HALF = NUM_CH / 2;

  logic [7:0]              gencfg;
  logic [NUM_CH-1:0]       ch_en;
  logic [NUM_CH-1:0][7:0]  fn_rd_ch, act_rd_ch;
  logic [NUM_CH-1:0]       shadow_drive;
  logic [7:0]              fn_val;

  wire              fn_wr    = wr_stb && (wr_addr >= A_FN_LO) && (wr_addr <= A_FN_HI);
  wire              rd_is_fn = (rd_addr >= A_FN_LO) && (rd_addr <= A_FN_HI);
  wire              commit   = wr_stb && (wr_addr == A_COMMIT) && wr_data[0];
  wire [IDX_W-1:0]  wr_fidx  = IDX_W'(wr_addr - A_FN_LO);
  wire [IDX_W-1:0]  rd_fidx  = IDX_W'(rd_addr - A_FN_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      gencfg <= '0;
      ch_en  <= '1;
    end else if (wr_stb) begin
      case (wr_addr)
        A_GENCFG:  gencfg <= wr_data;
        A_MASK_LO: ch_en[HALF-1:0] <= wr_data[HALF-1:0];
        A_MASK_HI: ch_en[NUM_CH-1:HALF] <= wr_data[NUM_CH-HALF-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [7:0] sh [FN_N];
    logic [7:0] ac [FN_N];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < FN_N; i++) begin
          sh[i] <= '0;
          ac[i] <= '0;
        end
      end else begin
        if (fn_wr && ch_en[c]) sh[wr_fidx] <= wr_data;
        if (commit) for (int i = 0; i < FN_N; i++) ac[i] <= sh[i];
      end
    end
    assign fn_rd_ch[c]     = sh[rd_fidx];
    assign act_rd_ch[c]    = ac[act_idx];
    assign lowpwr_mode[c]  = ac[DRIVE_IDX][DRIVE_BIT];
    assign shadow_drive[c] = sh[DRIVE_IDX][DRIVE_BIT];
  end

  always_comb begin
    fn_val = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (ch_en[c]) fn_val = fn_rd_ch[c];
  end

  always_comb begin
    rd_data = '0;
    if (rd_is_fn) rd_data = fn_val;
    else begin
      case (rd_addr)
        A_GENCFG:  rd_data = gencfg;
        A_CHIPID:  rd_data = CHIP_ID;
        A_GRADE:   rd_data = DEV_GRADE;
        A_MASK_LO: rd_data = 8'(ch_en[HALF-1:0]);
        A_MASK_HI: rd_data = 8'(ch_en[NUM_CH-1:HALF]);
        default:   rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         act_data <= '0;
    else if (int'(act_idx) < FN_N)   act_data <= act_rd_ch[act_ch];
    else                             act_data <= '0;
  end

  // R8
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> lowpwr_mode == $past(shadow_drive));
  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(lowpwr_mode));
  // R7
  no_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ch_en == '0) |=> $stable(shadow_drive));
endmodule

// File: rtl/spi3w_cfg_port.sv
module spi3w_cfg_port
  import spi3w_pkg::*;
#(
  parameter int         NUM_CH      = 8,
  parameter logic [7:0] CHIP_ID     = 8'h5A,
  parameter logic [7:0] DEV_GRADE   = 8'h03,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdio_i,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  input  logic [$clog2(NUM_CH)-1:0] act_ch,
  input  logic [$clog2(FN_N)-1:0]   act_idx,
  output logic [7:0]                act_data,
  output logic [NUM_CH-1:0]         lowpwr_mode
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] acc_addr, wr_addr;
  logic              wr_stb;
  logic [7:0]        wr_data, rd_data;

  spi3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdio_i}), .q(pins_s)
  );

  spi3w_serial u_serial (
    .clk(clk), .rst(rst), .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_data(rd_data), .acc_addr(acc_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  spi3w_regs #(.NUM_CH(NUM_CH), .CHIP_ID(CHIP_ID), .DEV_GRADE(DEV_GRADE)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(acc_addr), .rd_data(rd_data), .act_ch(act_ch), .act_idx(act_idx),
    .act_data(act_data), .lowpwr_mode(lowpwr_mode)
  );
endmodule

// File: tb/test_spi3w_cfg_port.sv
module test_spi3w_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int NV         = 33;

  logic       clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic       sdio_o, sdio_oe;
  logic [2:0] act_ch = '0;
  logic [4:0] act_idx = '0;
  logic [7:0] act_data, lowpwr_mode;

  int n_chk = 0, n_fail = 0, oe_bad = 0, chg_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3w_cfg_port i_spi3w_cfg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .act_ch(act_ch), .act_idx(act_idx),
    .act_data(act_data), .lowpwr_mode(lowpwr_mode)
  );

  // {tag, rw, addr, wdata, expected}
  localparam logic [33:0] VECS [NV] = '{
    {4'd5, 1'b1, 13'h000, 8'h00, 8'h00}, {4'd5, 1'b1, 13'h001, 8'h00, 8'h5A},
    {4'd5, 1'b1, 13'h002, 8'h00, 8'h03}, {4'd5, 1'b0, 13'h000, 8'hA5, 8'h00},
    {4'd5, 1'b1, 13'h000, 8'h00, 8'hA5}, {4'd5, 1'b0, 13'h001, 8'hFF, 8'h00},
    {4'd5, 1'b1, 13'h001, 8'h00, 8'h5A}, {4'd5, 1'b0, 13'h002, 8'h11, 8'h00},
    {4'd5, 1'b1, 13'h002, 8'h00, 8'h03}, {4'd6, 1'b1, 13'h004, 8'h00, 8'h0F},
    {4'd6, 1'b1, 13'h005, 8'h00, 8'h0F}, {4'd10, 1'b0, 13'h003, 8'h77, 8'h00},
    {4'd10, 1'b1, 13'h003, 8'h00, 8'h00}, {4'd10, 1'b0, 13'h100, 8'h33, 8'h00},
    {4'd10, 1'b1, 13'h100, 8'h00, 8'h00}, {4'd10, 1'b0, 13'h023, 8'h44, 8'h00},
    {4'd10, 1'b1, 13'h023, 8'h00, 8'h00}, {4'd8, 1'b1, 13'h0FF, 8'h00, 8'h00},
    {4'd7, 1'b0, 13'h008, 8'h3C, 8'h00}, {4'd7, 1'b1, 13'h008, 8'h00, 8'h3C},
    {4'd6, 1'b0, 13'h004, 8'hF2, 8'h00}, {4'd6, 1'b1, 13'h004, 8'h00, 8'h02},
    {4'd6, 1'b0, 13'h005, 8'h00, 8'h00}, {4'd6, 1'b1, 13'h005, 8'h00, 8'h00},
    {4'd7, 1'b0, 13'h008, 8'hC3, 8'h00}, {4'd7, 1'b1, 13'h008, 8'h00, 8'hC3},
    {4'd6, 1'b0, 13'h004, 8'h01, 8'h00}, {4'd7, 1'b1, 13'h008, 8'h00, 8'h3C},
    {4'd7, 1'b0, 13'h004, 8'h00, 8'h00}, {4'd7, 1'b1, 13'h008, 8'h00, 8'h00},
    {4'd6, 1'b0, 13'h004, 8'h0F, 8'h00}, {4'd6, 1'b0, 13'h005, 8'h0F, 8'h00},
    {4'd6, 1'b1, 13'h005, 8'h00, 8'h0F}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input logic b, output logic so, output logic soe);
    sdio_i = b;
    wait_clk(HALF_SCK);
    so  = sdio_o;
    soe = sdio_oe;
    sclk = 1'b1;
    wait_clk(HALF_SCK);
    if (soe && sdio_o !== so) chg_bad++;
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic rw, input logic [1:0] wc, input logic [12:0] a,
                      input int nb, input logic [7:0] wd [8],
                      output logic [7:0] rd [8], output logic [7:0] oe_mask);
    logic [15:0] h;
    logic so, soe;
    h = {rw, wc, a};
    oe_mask = '0;
    for (int k = 0; k < 8; k++) rd[k] = '0;
    cs_n = 1'b0;
    wait_clk(HALF_SCK);
    for (int i = 15; i >= 0; i--) begin
      sck_bit(h[i], so, soe);
      if (soe) oe_bad++;
    end
    for (int k = 0; k < nb; k++) begin
      for (int b = 7; b >= 0; b--) begin
        sck_bit(rw ? 1'b0 : wd[k][b], so, soe);
        rd[k][b] = so;
        if (b == 7) oe_mask[k] = soe;
        if (!rw && soe) oe_bad++;
      end
    end
    wait_clk(HALF_SCK);
    cs_n = 1'b1;
    wait_clk(HALF_SCK);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] wd [8];
    logic [7:0] rd [8];
    logic [7:0] m;
    for (int k = 0; k < 8; k++) wd[k] = d;
    xfer(1'b0, 2'b00, a, 1, wd, rd, m);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    logic [7:0] wd [8];
    logic [7:0] rd [8];
    logic [7:0] m;
    for (int k = 0; k < 8; k++) wd[k] = '0;
    xfer(1'b1, 2'b00, a, 1, wd, rd, m);
    d = rd[0];
  endtask

  task automatic act_look(input logic [2:0] c, input logic [4:0] i, output logic [7:0] d);
    act_ch = c;
    act_idx = i;
    wait_clk(2);
    d = act_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, m;
    logic [7:0] wd [8];
    logic [7:0] rd [8];
    logic so, soe;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    // reset state
    chk("R4 reset oe", 32'(sdio_oe), 32'd0);
    chk("R9 reset drive", 32'(lowpwr_mode), 32'h00);
    act_look(3'd0, 5'd0, v);
    chk("R11 reset lookup", 32'(v), 32'h00);

    for (int n = 0; n < NV; n++) begin
      if (VECS[n][29]) begin
        rd1(VECS[n][28:16], v);
        chk(tag_name(VECS[n][33:30]), 32'(v), 32'(VECS[n][7:0]));
      end else begin
        wr1(VECS[n][28:16], VECS[n][15:8]);
      end
    end

    // R1: A12 is decoded, 0x1000 must not alias onto 0x000
    wr1(13'h1000, 8'h55);
    rd1(13'h000, v);
    chk("R1 high address bit", 32'(v), 32'hA5);

    // R8 / R11: nothing active before commit
    act_look(3'd1, 5'd0, v);
    chk("R11 before commit", 32'(v), 32'h00);
    wr1(13'h0FF, 8'h01);
    act_look(3'd1, 5'd0, v);
    chk("R11 ch1 after commit", 32'(v), 32'hC3);
    act_look(3'd0, 5'd0, v);
    chk("R11 ch0 after commit", 32'(v), 32'h3C);
    act_look(3'd7, 5'd0, v);
    chk("R11 ch7 after commit", 32'(v), 32'h3C);
    act_look(3'd0, 5'd31, v);
    chk("R11 index out of range", 32'(v), 32'h00);
    rd1(13'h0FF, v);
    chk("R8 commit reads zero", 32'(v), 32'h00);

    // R9 drive select through commit
    wr1(13'h014, 8'h40);
    chk("R8 no commit yet", 32'(lowpwr_mode), 32'h00);
    wr1(13'h0FF, 8'h01);
    chk("R9 all reduced swing", 32'(lowpwr_mode), 32'hFF);
    wr1(13'h004, 8'h04);
    wr1(13'h005, 8'h00);
    wr1(13'h014, 8'h00);
    wr1(13'h0FF, 8'h01);
    chk("R7 masked drive write", 32'(lowpwr_mode), 32'hFB);
    act_look(3'd3, 5'd12, v);
    chk("R11 ch3 drive byte", 32'(v), 32'h40);
    wr1(13'h004, 8'h0F);
    wr1(13'h005, 8'h0F);
    wr1(13'h014, 8'h00);
    wr1(13'h0FF, 8'h00);
    chk("R8 commit bit clear", 32'(lowpwr_mode), 32'hFB);
    wr1(13'h0FF, 8'h01);
    chk("R9 back to standard", 32'(lowpwr_mode), 32'h00);

    // R3: two-byte write, three bytes sent
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33;
    for (int k = 3; k < 8; k++) wd[k] = 8'h00;
    xfer(1'b0, 2'b01, 13'h009, 3, wd, rd, m);
    xfer(1'b1, 2'b11, 13'h009, 3, wd, rd, m);
    chk("R3 stream rd byte0", 32'(rd[0]), 32'h11);
    chk("R3 stream rd byte1", 32'(rd[1]), 32'h22);
    chk("R3 extra byte dropped", 32'(rd[2]), 32'h00);
    chk("R4 stream oe", 32'(m[2:0]), 32'h7);

    // R3: three-byte read, four clocked
    xfer(1'b1, 2'b10, 13'h000, 4, wd, rd, m);
    chk("R3 read 0x000", 32'(rd[0]), 32'hA5);
    chk("R3 read 0x001", 32'(rd[1]), 32'h5A);
    chk("R3 read 0x002", 32'(rd[2]), 32'h03);
    chk("R4 oe stops after count", 32'(m[3:0]), 32'h7);

    // R3: streaming write of five bytes
    for (int k = 0; k < 8; k++) wd[k] = 8'(k + 1);
    xfer(1'b0, 2'b11, 13'h00C, 5, wd, rd, m);
    xfer(1'b1, 2'b11, 13'h00C, 5, wd, rd, m);
    for (int k = 0; k < 5; k++) chk("R3 stream write", 32'(rd[k]), 32'(k + 1));

    // R2: clock and data toggled with select high
    for (int i = 0; i < 20; i++) begin
      sdio_i = i[0];
      sclk = ~sclk;
      wait_clk(4);
      if (sdio_oe) oe_bad++;
    end
    sclk = 1'b0;
    wait_clk(HALF_SCK);
    rd1(13'h000, v);
    chk("R2 idle activity ignored", 32'(v), 32'hA5);

    // R2: transfer cut mid-byte
    cs_n = 1'b0;
    wait_clk(HALF_SCK);
    for (int i = 15; i >= 0; i--) sck_bit(1'b0, so, soe);
    for (int i = 0; i < 4; i++) sck_bit(1'b1, so, soe);
    cs_n = 1'b1;
    wait_clk(2 * HALF_SCK);
    rd1(13'h000, v);
    chk("R2 partial byte dropped", 32'(v), 32'hA5);

    chk("R4 oe outside read data", 32'(oe_bad), 32'd0);
    chk("R4 data changes on falling edge", 32'(chg_bad), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule